// File: doc/BRIEF.md
# Serial Clock Synthesizer Loader

This block loads a programming word into an external frequency synthesizer over a two-wire, software-style serial link made of one clock line and one data line. A host pulses a start strobe with the word and a step period. The block then walks the pins through a fixed series of states: an unlock preamble, one four-state symbol per data bit, and a three-state trailer. At the end it leaves the two lines carrying the synthesizer's clock-select code.

Every pin state is held for a programmable number of system clocks, so the link can be slowed to suit the target part. The pins come straight from a register, so they never glitch. A busy flag covers the whole transfer. A one-cycle done pulse marks the moment the select code reaches the pins.

Top module: `clk_synth_prog`

## Requirements
- R1: After reset `pins_o` is 0, and `busy_o` and `done_o` are both low.
- R2: `pins_o` bit 0 is the clock line and bit 1 is the data line, giving NONE=0, CLK=1, DATA=2, BOTH=3. A transfer starts with the 18-state preamble NONE, DATA, then six pairs of BOTH, DATA, then NONE, CLK, NONE, CLK.
- R3: After the preamble, word bits 1 to 24 go out in that order, one symbol each. Bit 0 is never sent and has no effect on the pins.
- R4: A bit of value 1 is sent as CLK, NONE, DATA, BOTH. A bit of value 0 is sent as BOTH, DATA, NONE, CLK.
- R5: After the last symbol the pins show BOTH, DATA, BOTH.
- R6: After the trailer the pins take word bits 23:22, with bit 22 on the clock line. They hold that value until the next accepted start.
- R7: Each pin state lasts exactly L clocks. L is `step_len_i` sampled at the accepted start, with 0 treated as 1. A full transfer therefore keeps `busy_o` high for 117·L cycles.
- R8: A start while `busy_o` is high is ignored. The word, the step period and the timing of the transfer in progress do not change.
- R9: `done_o` is high for exactly one cycle. That is the cycle in which the select code first appears and `busy_o` is low.
- R10: A start is accepted when `busy_o` is low. The first preamble state appears on the next cycle, together with `busy_o` going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| word_i | input | 25 | Programming word, sampled at start |
| step_len_i | input | 8 | Clocks per pin state, sampled at start (0 means 1) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the select code is applied |
| pins_o | output | 2 | Bit 0 is the serial clock line, bit 1 is the serial data line |

## Verification
Several corner cases are targeted:
- Word pairs that differ only in bit 0 must produce identical pin streams. A design that sends bit 0 would shift every symbol by one bit.
- Step periods of 0, 1, 2 and 3 expose off-by-one hold counts, and a zero period that stalls the link or wraps to 256.
- A start pulse in the middle of a transfer, carrying a different word and period, must leave the stream untouched. A design that re-arms would restart the preamble or change the period.
- Each run's stream is cut back into states and checked for preamble, symbol shapes, trailer and select. This catches swapped one/zero symbols, reversed bit order and select bits taken from the wrong place.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  typedef enum logic [1:0] {
    PIN_IDLE = 2'b00,
    PIN_CK   = 2'b01,
    PIN_DT   = 2'b10,
    PIN_BOTH = 2'b11
  } pin_e;

  localparam int SYM_STEPS = 4;
  localparam int TRL_STEPS = 3;
  localparam int TAIL_STEPS = 4;

  function automatic int pre_len(input int pair_reps);
    return 2 + 2 * pair_reps + TAIL_STEPS;
  endfunction

  // four-state symbol shape for one data bit
  function automatic pin_e sym_pin(input logic b, input logic [1:0] ph);
    pin_e p;
    if (b) begin
      case (ph)
        2'd0:    p = PIN_CK;
        2'd1:    p = PIN_IDLE;
        2'd2:    p = PIN_DT;
        default: p = PIN_BOTH;
      endcase
    end else begin
      case (ph)
        2'd0:    p = PIN_BOTH;
        2'd1:    p = PIN_DT;
        2'd2:    p = PIN_IDLE;
        default: p = PIN_CK;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/csp_step_timer.sv
module csp_step_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  output logic             end_o
);

  logic [LEN_W-1:0] last_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      last_q <= (len_i == '0) ? '0 : len_i - 1'b1;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == last_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign end_o = run_i && (cnt_q == last_q);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_q); // R7
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(last_q)); // R8

endmodule

// File: rtl/csp_pattern.sv
module csp_pattern
  import clk_synth_pkg::*;
#(
  parameter int N_BITS    = 24,
  parameter int PAIR_REPS = 6,
  parameter int IDX_W     = 7
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N_BITS-1:0] bits_i,
  output pin_e              pin_o
);

  localparam int PRE_LEN  = pre_len(PAIR_REPS);
  localparam int UNLK_END = 2 + 2 * PAIR_REPS;
  localparam int BODY_END = PRE_LEN + SYM_STEPS * N_BITS;

  int   ii;
  int   off;
  logic cur;

  always_comb begin
    ii    = 32'(idx_i);
    off   = 0;
    cur   = 1'b0;
    pin_o = PIN_IDLE;
    if (ii < PRE_LEN) begin
      if (ii == 0)             pin_o = PIN_IDLE;
      else if (ii == 1)        pin_o = PIN_DT;
      else if (ii < UNLK_END)  pin_o = ((ii - 2) % 2 == 0) ? PIN_BOTH : PIN_DT;
      else                     pin_o = ((ii - UNLK_END) % 2 == 0) ? PIN_IDLE : PIN_CK;
    end else if (ii < BODY_END) begin
      off = ii - PRE_LEN;
      for (int k = 0; k < N_BITS; k++) begin
        if (k == off / SYM_STEPS) cur = bits_i[k];
      end
      pin_o = sym_pin(cur, 2'(off % SYM_STEPS));
    end else begin
      pin_o = (ii - BODY_END == 1) ? PIN_DT : PIN_BOTH;
    end
  end

endmodule

// File: rtl/clk_synth_prog.sv
module clk_synth_prog
  import clk_synth_pkg::*;
#(
  parameter int WORD_W    = 25,
  parameter int SEL_LSB   = 22,
  parameter int LEN_W     = 8,
  parameter int PAIR_REPS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LEN_W-1:0]  step_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        pins_o
);

  localparam int N_BITS = WORD_W - 1;
  localparam int TOTAL  = pre_len(PAIR_REPS) + SYM_STEPS * N_BITS + TRL_STEPS;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic              busy_q, done_q;
  logic [1:0]        pins_q;
  logic [IDX_W-1:0]  idx_q, pat_idx;
  logic [WORD_W-1:0] word_q;
  logic [N_BITS-1:0] pat_bits;
  logic              accept, step_end;
  pin_e              pat_pin;

  assign accept   = start_i && !busy_q;
  assign pat_idx  = accept ? '0 : idx_q + 1'b1;
  assign pat_bits = accept ? word_i[WORD_W-1:1] : word_q[WORD_W-1:1];

  csp_step_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (step_len_i),
    .run_i  (busy_q),
    .end_o  (step_end)
  );

  csp_pattern #(.N_BITS(N_BITS), .PAIR_REPS(PAIR_REPS), .IDX_W(IDX_W)) u_pattern (
    .idx_i  (pat_idx),
    .bits_i (pat_bits),
    .pin_o  (pat_pin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pins_q <= PIN_IDLE;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        word_q <= word_i;
        idx_q  <= '0;
        pins_q <= pat_pin;
      end else if (busy_q && step_end) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pins_q <= word_q[SEL_LSB +: 2];
        end else begin
          idx_q  <= idx_q + 1'b1;
          pins_q <= pat_pin;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign pins_o = pins_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R9
  AST_SEL_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (pins_q == word_q[SEL_LSB +: 2])); // R6
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !step_end) |=> $stable(pins_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(pins_q)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(word_q)); // R8
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX); // R2
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_q && pins_q == PIN_IDLE)); // R10

endmodule

// File: tb/clk_synth_prog_tb.sv
module clk_synth_prog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 117;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [24:0] word_i = '0;
  logic [7:0]  len_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  pins_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clk_synth_prog u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .word_i     (word_i),
    .step_len_i (len_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pins_o     (pins_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: queue of pin states, hold counter
  logic [1:0] mq[$];
  bit         m_busy, m_done;
  logic [1:0] m_pins, m_sel;
  int         m_len, m_cnt;

  function automatic void build(input logic [24:0] w);
    mq.delete();
    mq.push_back(2'd0); mq.push_back(2'd2);
    for (int r = 0; r < 6; r++) begin mq.push_back(2'd3); mq.push_back(2'd2); end
    mq.push_back(2'd0); mq.push_back(2'd1); mq.push_back(2'd0); mq.push_back(2'd1);
    for (int k = 0; k < 24; k++) begin
      if (w[k+1]) begin
        mq.push_back(2'd1); mq.push_back(2'd0); mq.push_back(2'd2); mq.push_back(2'd3);
      end else begin
        mq.push_back(2'd3); mq.push_back(2'd2); mq.push_back(2'd0); mq.push_back(2'd1);
      end
    end
    mq.push_back(2'd3); mq.push_back(2'd2); mq.push_back(2'd3);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_pins = 2'd0; m_cnt = 0; m_len = 1; m_sel = 2'd0;
      mq.delete();
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          build(word_i);
          m_len  = (len_i == 0) ? 1 : int'(len_i);
          m_sel  = word_i[23:22];
          m_pins = mq.pop_front();
          m_cnt  = 1;
          m_busy = 1;
        end
      end else if (m_cnt == m_len) begin
        if (mq.size() == 0) begin
          m_busy = 0; m_done = 1; m_pins = m_sel;
        end else begin
          m_pins = mq.pop_front();
          m_cnt  = 1;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk(pins_o == m_pins, "R2 R7", "pins vs model", pins_o, m_pins);
      chk(busy_o == m_busy, "R8 R10", "busy vs model", busy_o, m_busy);
      chk(done_o == m_done, "R9", "done vs model", done_o, m_done);
    end
  end

  task automatic run_txn(input logic [24:0] w, input int len, input bit poke);
    logic [1:0] samp[$];
    logic [1:0] st[$];
    logic [1:0] pre[$];
    logic [23:0] rec;
    int L, guard;
    bit bad;
    L = (len == 0) ? 1 : len;
    @(negedge clk);
    start_i = 1'b1; word_i = w; len_i = 8'(len);
    @(negedge clk);
    start_i = 1'b0; word_i = ~w; len_i = 8'd7;
    chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
    guard = 0;
    while (busy_o && guard < 5000) begin
      samp.push_back(pins_o);
      if (poke && samp.size() == 40) begin
        start_i = 1'b1; word_i = ~w; len_i = 8'd3;  // R8 start while busy
      end else begin
        start_i = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9", "done at end of transfer", done_o, 1);
    chk(pins_o == w[23:22], "R6", "select on pins", pins_o, w[23:22]);
    chk(samp.size() == STEPS * L, "R7", "busy cycles", samp.size(), STEPS * L);
    if (samp.size() == STEPS * L) begin
      bad = 0;
      for (int s = 0; s < STEPS; s++) begin
        st.push_back(samp[s*L]);
        for (int j = 1; j < L; j++) if (samp[s*L+j] != samp[s*L]) bad = 1;
      end
      chk(!bad, "R7", "state held for full period", bad, 0);
      pre.push_back(2'd0); pre.push_back(2'd2);
      for (int r = 0; r < 6; r++) begin pre.push_back(2'd3); pre.push_back(2'd2); end
      pre.push_back(2'd0); pre.push_back(2'd1); pre.push_back(2'd0); pre.push_back(2'd1);
      bad = 0;
      for (int s = 0; s < 18; s++) if (st[s] != pre[s]) bad = 1;
      chk(!bad, "R2", "preamble", bad, 0);
      bad = 0; rec = '0;
      for (int k = 0; k < 24; k++) begin
        int b;
        b = 18 + 4 * k;
        if (st[b] == 2'd1 && st[b+1] == 2'd0 && st[b+2] == 2'd2 && st[b+3] == 2'd3) rec[k] = 1'b1;
        else if (st[b] == 2'd3 && st[b+1] == 2'd2 && st[b+2] == 2'd0 && st[b+3] == 2'd1) rec[k] = 1'b0;
        else bad = 1;
      end
      chk(!bad, "R4", "symbol shapes", bad, 0);
      chk(rec == w[24:1], "R3", "recovered bits", rec, w[24:1]);
      bad = (st[114] != 2'd3) || (st[115] != 2'd2) || (st[116] != 2'd3);
      chk(!bad, "R5", "trailer", bad, 0);
    end
    repeat (5) @(negedge clk);
    chk(pins_o == w[23:22], "R6", "select held while idle", pins_o, w[23:22]);
    chk(busy_o == 1'b0, "R6", "idle after transfer", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pins_o == 2'd0, "R1", "reset pins", pins_o, 0);
    chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(25'h0A53C97, 1, 0);
    run_txn(25'h0A53C96, 3, 0);   // R3 bit 0 differs only
    run_txn(25'h1FFFFFF, 0, 0);   // R7 zero period
    run_txn(25'h0000000, 2, 0);
    run_txn(25'h1234567, 2, 1);   // R8 poke mid-transfer
    run_txn(25'h0855AA1, 1, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule